// File: doc/BRIEF.md
# PIO Strobe Count Calculator

This block turns nanosecond timing targets for a programmed-I/O disk transfer into the clock counts that a strobe generator needs. A request carries a PIO mode number, the total cycle time in nanoseconds, the bus clock period in nanoseconds, a silicon revision value and, for drives sharing a channel, the counts already chosen for the partner drive. The block looks up the setup and active times of the mode in a small internal table, derives the recovery time, and performs four ceiling divisions on a single iterative subtract-and-count divider. It then applies the count limits and the revision correction, and, when asked, merges the result with the partner's counts.

Requests enter on a valid/ready port and results leave on a valid/ready port. The block works on one request at a time. `req_ready` is high only while the block is idle. Once a result is offered on `res_valid`, it stays unchanged until `res_ready` takes it, and no new request is accepted before that happens. Back-pressure on the result side therefore stalls the request side.

Top module: `pio_count_calc`

## Requirements
- R1: A mode value of 6 or 7 produces exactly the counts of mode 5.
- R2: The table gives these setup/active times in ns: mode 0 is 70/165, mode 1 is 50/125, mode 2 is 30/100, mode 3 is 30/80, mode 4 is 25/70 and mode 5 is 15/65. The setup count is ceil(setup_ns / period), and the cycle and active counts are derived in the same way.
- R3: The recovery time is cycle_ns minus (setup_ns + active_ns), with 0 used when that difference is negative. The recovery count is the larger of two values: ceil(recovery_ns / period), and the cycle count minus the setup count minus the active count after R4 is applied, with 0 used when that difference is negative.
- R4: The active count is raised to at least 2, and so is the recovery count (before R6).
- R5: A recovery count above 17 adds its excess to the active count and becomes 17. After that step, the active count is limited to 16.
- R6: When the revision is greater than 1, the recovery count is reduced by one. The recovery count is then limited to 16.
- R7: When both `req_shared` and `req_peer_present` are 1, each output count is the larger of the block's own count and the partner's count. Otherwise the partner inputs have no effect.
- R8: A period input of 0 selects the default period: 30 ns (1000/33) when `req_local_bus` is 0, and 20 ns (1000/50) when it is 1.
- R9: A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from that edge until the result has been taken. `res_valid` and the result fields stay stable until a cycle in which `res_ready` is high.
- R10: After reset, `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 3 | PIO mode number, 0 to 7 |
| req_cycle_ns | input | NS_W | Total cycle time in ns |
| req_clk_ns | input | CLK_W | Bus clock period in ns, 0 selects default |
| req_local_bus | input | 1 | Default period selector: 1 selects the local bus default |
| req_rev | input | REV_W | Silicon revision value |
| req_shared | input | 1 | Drive is on the shared channel |
| req_peer_present | input | 1 | Partner drive exists |
| req_peer_setup | input | NS_W | Partner setup count |
| req_peer_active | input | 5 | Partner active count |
| req_peer_recovery | input | 5 | Partner recovery count |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| res_setup | output | NS_W | Setup count |
| res_active | output | 5 | Active count |
| res_recovery | output | 5 | Recovery count |

## Verification
Two events can meet in one cycle: the result being taken, and a new request arriving. The bench provokes this by raising `res_ready` and `req_valid` together, with a fresh request already on the inputs. It then checks that the new request is not taken on that edge, that `req_ready` rises in the following cycle, and that the later result matches the new request's expected counts. Result-side stalls of varying length run throughout the sweep. During each stall the bench checks that the result fields stay stable and that `req_ready` stays low.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  localparam int MODE_W   = 3;
  localparam int MODE_TOP = 5;
  localparam int ACT_MIN  = 2;
  localparam int ACT_MAX  = 16;
  localparam int REC_MIN  = 2;
  localparam int REC_LIM  = 17;
  localparam int REC_MAX  = 16;
  localparam int CNT_W    = $clog2(REC_LIM + 1);

  typedef struct packed {
    logic [7:0] setup_ns;
    logic [7:0] active_ns;
  } pio_time_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_WAIT, ST_FIN, ST_OUT
  } calc_state_t;

  // Setup and active targets per mode; values above the top mode fold onto it
  function automatic pio_time_t mode_time(input logic [MODE_W-1:0] m);
    pio_time_t t;
    case (m)
      3'd0: t = '{setup_ns: 8'd70, active_ns: 8'd165};
      3'd1: t = '{setup_ns: 8'd50, active_ns: 8'd125};
      3'd2: t = '{setup_ns: 8'd30, active_ns: 8'd100};
      3'd3: t = '{setup_ns: 8'd30, active_ns: 8'd80};
      3'd4: t = '{setup_ns: 8'd25, active_ns: 8'd70};
      default: t = '{setup_ns: 8'd15, active_ns: 8'd65};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  logic [W-1:0] rem;

  // Each step removes one divisor, so a partial last step still counts: ceiling
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      quot <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= num;
        quot <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (rem == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem  <= (rem > den) ? rem - den : '0;
          quot <= quot + 1'b1;
        end
      end
    end
  end

  p_done_from_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_quot_hold_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !start) |-> $stable(quot));

endmodule

// File: rtl/pio_count_clamp.sv
module pio_count_clamp
  import pio_calc_pkg::*;
#(
  parameter int W     = 10,
  parameter int REV_W = 2
) (
  input  logic [W-1:0]     cyc_q,
  input  logic [W-1:0]     set_q,
  input  logic [W-1:0]     act_q,
  input  logic [W-1:0]     rec_q,
  input  logic [REV_W-1:0] rev,
  input  logic             merge,
  input  logic [W-1:0]     peer_set,
  input  logic [CNT_W-1:0] peer_act,
  input  logic [CNT_W-1:0] peer_rec,
  output logic [W-1:0]     set_o,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] rec_o
);
  localparam int XW = W + 2;

  logic [XW-1:0] act_x, sum_x, alt_x, rec_x;
  logic [CNT_W-1:0] own_act, own_rec;

  always_comb begin
    act_x = XW'(act_q);
    if (act_x < XW'(ACT_MIN)) act_x = XW'(ACT_MIN);
    sum_x = XW'(set_q) + act_x;
    alt_x = (XW'(cyc_q) >= sum_x) ? XW'(cyc_q) - sum_x : '0;
    rec_x = (XW'(rec_q) > alt_x) ? XW'(rec_q) : alt_x;
    if (rec_x < XW'(REC_MIN)) rec_x = XW'(REC_MIN);
    if (rec_x > XW'(REC_LIM)) begin
      act_x = act_x + (rec_x - XW'(REC_LIM));
      rec_x = XW'(REC_LIM);
    end
    if (act_x > XW'(ACT_MAX)) act_x = XW'(ACT_MAX);
    if (rev > REV_W'(1)) rec_x = rec_x - 1'b1;
    if (rec_x > XW'(REC_MAX)) rec_x = XW'(REC_MAX);
    own_act = act_x[CNT_W-1:0];
    own_rec = rec_x[CNT_W-1:0];
  end

  // Shared channel: slowest of the pair, field by field
  always_comb begin
    set_o = set_q;
    act_o = own_act;
    rec_o = own_rec;
    if (merge) begin
      if (peer_set > set_o) set_o = peer_set;
      if (peer_act > act_o) act_o = peer_act;
      if (peer_rec > rec_o) rec_o = peer_rec;
    end
  end

endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc
  import pio_calc_pkg::*;
#(
  parameter int NS_W      = 10,
  parameter int CLK_W     = 6,
  parameter int REV_W     = 2,
  parameter int PCI_MHZ   = 33,
  parameter int LOCAL_MHZ = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [NS_W-1:0]   req_cycle_ns,
  input  logic [CLK_W-1:0]  req_clk_ns,
  input  logic              req_local_bus,
  input  logic [REV_W-1:0]  req_rev,
  input  logic              req_shared,
  input  logic              req_peer_present,
  input  logic [NS_W-1:0]   req_peer_setup,
  input  logic [4:0]        req_peer_active,
  input  logic [4:0]        req_peer_recovery,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [NS_W-1:0]   res_setup,
  output logic [4:0]        res_active,
  output logic [4:0]        res_recovery
);
  localparam int PCI_NS   = 1000 / PCI_MHZ;
  localparam int LOCAL_NS = 1000 / LOCAL_MHZ;
  localparam int NOPS     = 4;
  localparam int IDX_W    = $clog2(NOPS);

  calc_state_t state;
  logic [IDX_W-1:0] idx;
  logic [NS_W-1:0]  num_q [NOPS];
  logic [NS_W-1:0]  quo_q [NOPS];
  logic [NS_W-1:0]  den_q;
  logic [REV_W-1:0] rev_q;
  logic             merge_q;
  logic [NS_W-1:0]  peer_set_q;
  logic [4:0]       peer_act_q, peer_rec_q;

  logic [2:0]       mode_sat;
  pio_time_t        tm;
  logic [NS_W:0]    busy_ns;
  logic [NS_W-1:0]  rec_ns;
  logic [CLK_W-1:0] period;
  logic             accept;

  logic            div_start, div_busy, div_done;
  logic [NS_W-1:0] div_quot;
  logic [NS_W-1:0] c_set;
  logic [4:0]      c_act, c_rec;

  assign accept   = req_valid && req_ready;
  assign mode_sat = (req_mode > 3'(MODE_TOP)) ? 3'(MODE_TOP) : req_mode;
  assign tm       = mode_time(mode_sat);
  assign busy_ns  = (NS_W+1)'(tm.setup_ns) + (NS_W+1)'(tm.active_ns);
  assign rec_ns   = ((NS_W+1)'(req_cycle_ns) >= busy_ns)
                  ? NS_W'((NS_W+1)'(req_cycle_ns) - busy_ns) : '0;
  assign period   = (req_clk_ns != '0) ? req_clk_ns
                  : (req_local_bus ? CLK_W'(LOCAL_NS) : CLK_W'(PCI_NS));

  assign req_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_OUT);
  assign div_start = (state == ST_LAUNCH);

  pio_ceil_div #(.W(NS_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (num_q[idx]),
    .den   (den_q),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  pio_count_clamp #(.W(NS_W), .REV_W(REV_W)) u_clamp (
    .cyc_q    (quo_q[0]),
    .set_q    (quo_q[1]),
    .act_q    (quo_q[2]),
    .rec_q    (quo_q[3]),
    .rev      (rev_q),
    .merge    (merge_q),
    .peer_set (peer_set_q),
    .peer_act (peer_act_q),
    .peer_rec (peer_rec_q),
    .set_o    (c_set),
    .act_o    (c_act),
    .rec_o    (c_rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      idx          <= '0;
      den_q        <= '0;
      rev_q        <= '0;
      merge_q      <= 1'b0;
      peer_set_q   <= '0;
      peer_act_q   <= '0;
      peer_rec_q   <= '0;
      res_setup    <= '0;
      res_active   <= '0;
      res_recovery <= '0;
      for (int i = 0; i < NOPS; i++) begin
        num_q[i] <= '0;
        quo_q[i] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          num_q[0]   <= req_cycle_ns;
          num_q[1]   <= NS_W'(tm.setup_ns);
          num_q[2]   <= NS_W'(tm.active_ns);
          num_q[3]   <= rec_ns;
          den_q      <= NS_W'(period);
          rev_q      <= req_rev;
          merge_q    <= req_shared && req_peer_present;
          peer_set_q <= req_peer_setup;
          peer_act_q <= req_peer_active;
          peer_rec_q <= req_peer_recovery;
          idx        <= '0;
          state      <= ST_LAUNCH;
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          quo_q[idx] <= div_quot;
          if (idx == IDX_W'(NOPS - 1)) state <= ST_FIN;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_LAUNCH;
          end
        end
        ST_FIN: begin
          res_setup    <= c_set;
          res_active   <= c_act;
          res_recovery <= c_rec;
          state        <= ST_OUT;
        end
        ST_OUT: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_setup)
      && $stable(res_active) && $stable(res_recovery)));
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));
  p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
  p_act_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !merge_q) |-> (res_active >= 5'(ACT_MIN) && res_active <= 5'(ACT_MAX)));
  p_rec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !merge_q) |-> (res_recovery >= 5'(REC_MIN - 1) && res_recovery <= 5'(REC_LIM)));
  p_merge_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && merge_q) |-> (res_setup >= peer_set_q && res_active >= peer_act_q
      && res_recovery >= peer_rec_q));
  p_div_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state == ST_WAIT));

endmodule

// File: tb/pio_count_calc_bench.sv
module pio_count_calc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_mode = '0;
  logic [9:0] req_cycle_ns = '0;
  logic [5:0] req_clk_ns = '0;
  logic req_local_bus = 1'b0;
  logic [1:0] req_rev = '0;
  logic req_shared = 1'b0, req_peer_present = 1'b0;
  logic [9:0] req_peer_setup = '0;
  logic [4:0] req_peer_active = '0, req_peer_recovery = '0;
  logic res_valid, res_ready = 1'b0;
  logic [9:0] res_setup;
  logic [4:0] res_active, res_recovery;

  int checks = 0, fails = 0, cyc_cnt = 0;
  bit done_flag = 0;

  pio_count_calc u_pio_count_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_cycle_ns(req_cycle_ns), .req_clk_ns(req_clk_ns),
    .req_local_bus(req_local_bus), .req_rev(req_rev), .req_shared(req_shared),
    .req_peer_present(req_peer_present), .req_peer_setup(req_peer_setup),
    .req_peer_active(req_peer_active), .req_peer_recovery(req_peer_recovery),
    .res_valid(res_valid), .res_ready(res_ready), .res_setup(res_setup),
    .res_active(res_active), .res_recovery(res_recovery));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  // Reference model built from the requirement text
  task automatic model(input int mode, input int cyc, input int clkn, input bit loc,
                       input int rev, input bit mrg, input int ps, input int pa,
                       input int pr, output int es, output int ea, output int er);
    int m, st, at, rt, p, cc, r1, r2;
    m = (mode > 5) ? 5 : mode;                                   // R1
    case (m)
      0: begin st = 70; at = 165; end
      1: begin st = 50; at = 125; end
      2: begin st = 30; at = 100; end
      3: begin st = 30; at = 80; end
      4: begin st = 25; at = 70; end
      default: begin st = 15; at = 65; end
    endcase
    p = (clkn != 0) ? clkn : (loc ? 20 : 30);                    // R8
    rt = (cyc >= st + at) ? cyc - st - at : 0;
    cc = cdiv(cyc, p); es = cdiv(st, p); ea = cdiv(at, p);       // R2
    if (ea < 2) ea = 2;                                          // R4
    r1 = cdiv(rt, p);
    r2 = (cc >= es + ea) ? cc - es - ea : 0;                     // R3
    er = (r1 > r2) ? r1 : r2;
    if (er < 2) er = 2;
    if (er > 17) begin ea = ea + er - 17; er = 17; end          // R5
    if (ea > 16) ea = 16;
    if (rev > 1) er = er - 1;                                    // R6
    if (er > 16) er = 16;
    if (mrg) begin                                               // R7
      if (ps > es) es = ps;
      if (pa > ea) ea = pa;
      if (pr > er) er = pr;
    end
  endtask

  task automatic run(input int mode, input int cyc, input int clkn, input bit loc,
                     input int rev, input bit sh, input bit pp, input int ps,
                     input int pa, input int pr, input int stall, input string tag);
    int es, ea, er, s0, a0, r0;
    model(mode, cyc, clkn, loc, rev, sh && pp, ps, pa, pr, es, ea, er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = 3'(mode); req_cycle_ns = 10'(cyc);
    req_clk_ns = 6'(clkn); req_local_bus = loc; req_rev = 2'(rev);
    req_shared = sh; req_peer_present = pp; req_peer_setup = 10'(ps);
    req_peer_active = 5'(pa); req_peer_recovery = 5'(pr);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 ready drops after accept", int'(req_ready), 0);
    while (!res_valid) @(negedge clk);
    chk({tag, " setup"}, int'(res_setup), es);
    chk({tag, " active"}, int'(res_active), ea);
    chk({tag, " recovery"}, int'(res_recovery), er);
    s0 = res_setup; a0 = res_active; r0 = res_recovery;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R9 result held", int'(res_valid && res_setup == 10'(s0) &&
          res_active == 5'(a0) && res_recovery == 5'(r0) && !req_ready), 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R9 released", int'(res_valid), 0);
  endtask

  initial begin
    int clks[6] = '{0, 0, 7, 16, 25, 33};
    int cycs[6] = '{0, 120, 240, 383, 600, 1023};
    int n = 0, es, ea, er;
    string tg;
    repeat (3) @(negedge clk);
    chk("R10 ready after reset", int'(req_ready), 1);
    chk("R10 valid after reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready out of reset", int'(req_ready), 1);

    // Sweep of modes, cycle times, periods and revisions
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 6; c++)
        for (int k = 0; k < 6; k++)
          for (int r = 1; r < 3; r++) begin
            if (m > 5) tg = "R1";
            else if (clks[k] == 0) tg = "R8";
            else if (r > 1) tg = "R6";
            else tg = "R2 R3 R4 R5";
            run(m, cycs[c], clks[k], (k == 1), r, 1'b0, 1'b0, 0, 0, 0, n % 3, tg);
            n++;
          end

    // Shared-channel merge and its ignore cases
    for (int m = 0; m < 6; m++)
      for (int r = 2; r < 4; r++)
        for (int v = 0; v < 3; v++) begin
          run(m, 240, 30, 1'b0, r, 1'b1, 1'b1, 1 + v * 3, 3 + v * 6, 2 + v * 7, 0, "R7 merge");
          run(m, 240, 30, 1'b0, r, 1'b1, 1'b0, 9, 16, 17, 1, "R7 no partner");
          run(m, 240, 30, 1'b0, r, 1'b0, 1'b1, 9, 16, 17, 0, "R7 not shared");
        end

    // Result release and new request in the same cycle
    run(2, 383, 30, 1'b0, 1, 1'b0, 1'b0, 0, 0, 0, 0, "R9 pre");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd0; req_cycle_ns = 10'd600; req_clk_ns = 6'd20;
    req_rev = 2'd2; req_shared = 1'b0; req_peer_present = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd4; req_cycle_ns = 10'd120; req_clk_ns = 6'd16;
    req_rev = 2'd1; res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R9 release cycle valid", int'(res_valid), 0);
    chk("R9 ready after release", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 overlap request taken late", int'(req_ready), 0);
    while (!res_valid) @(negedge clk);
    model(4, 120, 16, 1'b0, 1, 1'b0, 0, 0, 0, es, ea, er);
    chk("R9 overlap setup", int'(res_setup), es);
    chk("R9 overlap active", int'(res_active), ea);
    chk("R9 overlap recovery", int'(res_recovery), er);
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;

    done_flag = 1;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (done_flag || cyc_cnt > 190000) begin
      if (!done_flag) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule